// File: doc/BRIEF.md
# SPI host command engine

This block is a serial-peripheral master that performs one whole SPI transaction each time software launches a command. Software first loads a 24-bit address register and a 128-bit data register. It then writes a command word. That word names an 8-bit opcode and picks one of two attached devices: a flash part or an EEPROM. It also gives how many address bytes, dummy bytes and data bytes to send, and whether the data moves out of the block or into it.

The engine lowers the chosen chip select and sends the opcode. The address follows, most significant byte first, then zero-valued dummy bytes. Last comes the data phase, which either sends bytes from the data register or captures bytes into it. A command-enable flag stays high from launch until the chip select has been high for a full SCLK period. A write-timer flag then covers the device's internal programming time after any outgoing data transfer. Each device has its own 7-bit divisor, which sets the SCLK rate derived from the reference clock.

Top module: `spiHostEngine`

## Requirements
- R1: A `cmdWr` pulse while `cmdEnable` is 0 starts a transaction, and `cmdEnable` reads 1 from the next cycle until the transaction has ended. A `cmdWr` pulse while `cmdEnable` is 1 is ignored: nothing is sent and nothing is queued.
- R2: The frame is sent MSB first in this order: the opcode byte, then the address bytes, then the dummy bytes, then the data bytes. With N address bytes, address byte j (j = 1..N) is `addrIn` bits [8(N-j)+7 : 8(N-j)]. Dummy bytes are 0x00.
- R3: An address byte count of 0 sends no address phase, and a dummy byte count of 0 sends no dummy phase. The frame length is exactly 8 x (1 + address + dummy + data) bits.
- R4: In an outgoing transfer, data byte i is bits [8i+7:8i] of the data register. In a read (`cmdRead`=1), MOSI is 0 during the data phase. The byte sampled from MISO for data byte i replaces bits [8i+7:8i] of `dataOut`, and the other bytes keep their values.
- R5: `cmdDevSel`=0 drives `csN[0]` low and `cmdDevSel`=1 drives `csN[1]` low. The other select stays high, and at most one select is low at any time.
- R6: The SCLK half-period is max(1, ceil(d/2)) reference cycles, where d is the divisor of the selected device (`divFlash` or `divEeprom`).
- R7: SPI mode 0. SCLK is low whenever both selects are high. The chip select falls exactly one half-period before the first SCLK rise and rises at the last SCLK fall. `cmdEnable` then stays 1 for exactly two more half-periods.
- R8: After an outgoing transfer with at least one data byte, `wrTimerActive` is 1 for exactly WR_TIMER_CYCLES cycles, starting in the cycle in which `cmdEnable` clears. After a read, or after an outgoing transfer with no data bytes, it stays 0.
- R9: A data byte count above 16 is treated as 16 and sets `errSticky`, which stays 1 until reset.
- R10: After reset, `cmdEnable`, `wrTimerActive`, `errSticky`, `sclk` and `dataOut` are 0 and `csN` is 2'b11.
- R11: Writes to the address or data register while `cmdEnable` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrWr | input | 1 | Load strobe for the address register |
| addrIn | input | 24 | Address value |
| dataWr | input | 1 | Load strobe for the data register |
| dataIn | input | 128 | Data register value, byte 0 in bits [7:0] |
| cmdWr | input | 1 | Command write strobe; launches a transaction |
| cmdOpcode | input | 8 | Opcode byte |
| cmdDevSel | input | 1 | 0 = flash, 1 = EEPROM |
| cmdAddrBytes | input | 2 | Address byte count (0..3) |
| cmdDummyBytes | input | 2 | Dummy byte count (0..3) |
| cmdDataBytes | input | 5 | Data byte count (clamped to 16) |
| cmdRead | input | 1 | 1 = capture data from MISO |
| divFlash | input | 7 | SCLK divisor for the flash device |
| divEeprom | input | 7 | SCLK divisor for the EEPROM device |
| cmdEnable | output | 1 | Transaction in progress |
| wrTimerActive | output | 1 | Post-write programming window |
| errSticky | output | 1 | Data byte count was clamped |
| dataOut | output | 128 | Data register contents |
| sclk | output | 1 | Serial clock |
| csN | output | 2 | Active-low chip selects, [0] flash, [1] EEPROM |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench keeps the default byte-count limits but sets WR_TIMER_CYCLES to 20, so the length of the post-write window can be counted in full. The divisors are driven from the bench. Small values (1 and 4) keep each frame short enough to run every stimulus vector in full, including a 16-byte burst and a 20-byte clamp. The value 7 makes the half-period large enough that the chip-select lead time, the SCLK period and the trailing gap can each be counted cycle by cycle.

// File: rtl/spiHostPkg.sv
package spiHostPkg;

  // Wide enough for 1 opcode + 3 address + 3 dummy + 16 data byte positions
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT} phaseT;

  typedef struct packed {
    phaseT            ph;
    logic [IDX_W-1:0] idx;
  } byteSlotT;

  typedef struct packed {
    logic             start;
    logic             load;
    logic             shift;
    logic             sample;
    logic             commit;
    logic             readDir;
    logic [IDX_W-1:0] addrCnt;
    byteSlotT         loadSlot;
    byteSlotT         curSlot;
  } ctrlStrobeT;

  // Map a frame byte position onto its phase and the index inside that phase
  function automatic byteSlotT locateByte(input logic [IDX_W-1:0] b,
                                          input logic [IDX_W-1:0] a,
                                          input logic [IDX_W-1:0] d);
    byteSlotT s;
    if (b == '0) begin
      s.ph  = PH_OPC;
      s.idx = '0;
    end else if (b <= a) begin
      s.ph  = PH_ADR;
      s.idx = b - 1'b1;
    end else if (b <= a + d) begin
      s.ph  = PH_DUM;
      s.idx = b - 1'b1 - a;
    end else begin
      s.ph  = PH_DAT;
      s.idx = b - 1'b1 - a - d;
    end
    return s;
  endfunction

endpackage

// File: rtl/spiHostCtrl.sv
module spiHostCtrl
  import spiHostPkg::*;
#(
  parameter int DIV_W           = 7,
  parameter int DATA_BYTES      = 16,
  parameter int ADDR_CNT_W      = 2,
  parameter int DUMMY_CNT_W     = 2,
  parameter int DCNT_W          = 5,
  parameter int WR_TIMER_CYCLES = 12500
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdWr,
  input  logic                   cmdDevSel,
  input  logic [ADDR_CNT_W-1:0]  cmdAddrBytes,
  input  logic [DUMMY_CNT_W-1:0] cmdDummyBytes,
  input  logic [DCNT_W-1:0]      cmdDataBytes,
  input  logic                   cmdRead,
  input  logic [DIV_W-1:0]       divFlash,
  input  logic [DIV_W-1:0]       divEeprom,
  output ctrlStrobeT             stb,
  output logic                   cmdEnable,
  output logic                   sclk,
  output logic [1:0]             csN,
  output logic                   wrTimerActive,
  output logic                   errSticky
);

  localparam int TMR_W = $clog2(WR_TIMER_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WR_TIMER_CYCLES);
  localparam logic [DCNT_W-1:0] DATA_MAX = DCNT_W'(DATA_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} stateT;

  stateT             state;
  logic [DIV_W:0]    hp;
  logic [DIV_W+1:0]  tick;
  logic [2:0]        bitCnt;
  logic [IDX_W-1:0]  byteIdx, lastIdx, aCnt, dCnt;
  logic [DCNT_W-1:0] nEff;
  logic              isRead;
  logic [TMR_W-1:0]  timer;

  logic [DIV_W:0]    divPlus, halfSel;
  logic [DCNT_W-1:0] nClamp;
  logic              overLimit, tickEnd, gapEnd, rise, fall;

  always_comb begin
    divPlus   = {1'b0, (cmdDevSel ? divEeprom : divFlash)} + 1'b1;
    halfSel   = divPlus >> 1;
    if (halfSel == '0) halfSel = 1;
    overLimit = cmdDataBytes > DATA_MAX;
    nClamp    = overLimit ? DATA_MAX : cmdDataBytes;
    tickEnd   = tick == ({1'b0, hp} - 1'b1);
    gapEnd    = tick == ({hp, 1'b0} - 1'b1);
    rise      = (state == ST_SHIFT) && tickEnd && !sclk;
    fall      = (state == ST_SHIFT) && tickEnd && sclk;
  end

  always_comb begin
    stb.start    = (state == ST_IDLE) && cmdWr;
    stb.sample   = rise;
    stb.commit   = rise && (bitCnt == 3'd7);
    stb.shift    = fall && (bitCnt != 3'd7);
    stb.load     = fall && (bitCnt == 3'd7) && (byteIdx != lastIdx);
    stb.readDir  = isRead;
    stb.addrCnt  = aCnt;
    stb.loadSlot = locateByte(byteIdx + 1'b1, aCnt, dCnt);
    stb.curSlot  = locateByte(byteIdx, aCnt, dCnt);
  end

  assign wrTimerActive = timer != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cmdEnable <= 1'b0;
      sclk      <= 1'b0;
      csN       <= 2'b11;
      hp        <= '0;
      tick      <= '0;
      bitCnt    <= '0;
      byteIdx   <= '0;
      lastIdx   <= '0;
      aCnt      <= '0;
      dCnt      <= '0;
      nEff      <= '0;
      isRead    <= 1'b0;
      timer     <= '0;
      errSticky <= 1'b0;
    end else begin
      if (timer != '0) timer <= timer - 1'b1;
      case (state)
        ST_IDLE: if (cmdWr) begin
          state     <= ST_SHIFT;
          cmdEnable <= 1'b1;
          csN       <= cmdDevSel ? 2'b01 : 2'b10;
          hp        <= halfSel;
          tick      <= '0;
          sclk      <= 1'b0;
          bitCnt    <= '0;
          byteIdx   <= '0;
          aCnt      <= IDX_W'(cmdAddrBytes);
          dCnt      <= IDX_W'(cmdDummyBytes);
          nEff      <= nClamp;
          lastIdx   <= IDX_W'(cmdAddrBytes) + IDX_W'(cmdDummyBytes) + IDX_W'(nClamp);
          isRead    <= cmdRead;
          if (overLimit) errSticky <= 1'b1;
        end
        ST_SHIFT: if (tickEnd) begin
          tick <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitCnt == 3'd7) begin
              bitCnt <= '0;
              if (byteIdx == lastIdx) begin
                state <= ST_GAP;
                csN   <= 2'b11;
              end else begin
                byteIdx <= byteIdx + 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          tick <= tick + 1'b1;
        end
        ST_GAP: if (gapEnd) begin
          state     <= ST_IDLE;
          cmdEnable <= 1'b0;
          tick      <= '0;
          if (!isRead && nEff != '0) timer <= TMR_LOAD;
        end else begin
          tick <= tick + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spiHostDatapath.sv
module spiHostDatapath
  import spiHostPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobeT              stb,
  input  logic                    busy,
  input  logic                    addrWr,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    dataWr,
  input  logic [8*DATA_BYTES-1:0] dataIn,
  input  logic [7:0]              cmdOpcode,
  input  logic                    miso,
  output logic                    mosi,
  output logic [8*DATA_BYTES-1:0] dataOut
);

  localparam int BYTE_IDX_W = $clog2(DATA_BYTES);

  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataBytes [DATA_BYTES];
  logic [7:0]        txShift, rxShift, txByte;
  logic [IDX_W-1:0]  addrSel;
  logic [IDX_W+2:0]  bitOff;
  logic [ADDR_W-1:0] addrShifted;

  always_comb begin
    addrSel     = stb.addrCnt - 1'b1 - stb.loadSlot.idx;
    bitOff      = {addrSel, 3'b000};
    addrShifted = addrReg >> bitOff;
    case (stb.loadSlot.ph)
      PH_ADR:  txByte = addrShifted[7:0];
      PH_DAT:  txByte = stb.readDir ? 8'h00
                                    : dataBytes[stb.loadSlot.idx[BYTE_IDX_W-1:0]];
      default: txByte = 8'h00;
    endcase
  end

  assign mosi = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (addrWr && !busy) addrReg <= addrIn;
      if (stb.start)       txShift <= cmdOpcode;
      else if (stb.load)   txShift <= txByte;
      else if (stb.shift)  txShift <= {txShift[6:0], 1'b0};
      if (stb.sample)      rxShift <= {rxShift[6:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_BYTES; i++) dataBytes[i] <= '0;
    end else if (dataWr && !busy) begin
      for (int i = 0; i < DATA_BYTES; i++) dataBytes[i] <= dataIn[8*i +: 8];
    end else if (stb.commit && stb.readDir && stb.curSlot.ph == PH_DAT) begin
      dataBytes[stb.curSlot.idx[BYTE_IDX_W-1:0]] <= {rxShift[6:0], miso};
    end
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : gOut
    assign dataOut[8*g +: 8] = dataBytes[g];
  end

endmodule

// File: rtl/spiHostEngine.sv
module spiHostEngine
  import spiHostPkg::*;
#(
  parameter int ADDR_BYTES_MAX  = 3,
  parameter int DUMMY_MAX       = 3,
  parameter int DATA_BYTES      = 16,
  parameter int DIV_W           = 7,
  parameter int WR_TIMER_CYCLES = 12500,
  localparam int ADDR_W         = 8 * ADDR_BYTES_MAX,
  localparam int ADDR_CNT_W     = $clog2(ADDR_BYTES_MAX + 1),
  localparam int DUMMY_CNT_W    = $clog2(DUMMY_MAX + 1),
  localparam int DCNT_W         = $clog2(DATA_BYTES) + 1,
  localparam int DATA_W         = 8 * DATA_BYTES
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   addrWr,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic                   dataWr,
  input  logic [DATA_W-1:0]      dataIn,
  input  logic                   cmdWr,
  input  logic [7:0]             cmdOpcode,
  input  logic                   cmdDevSel,
  input  logic [ADDR_CNT_W-1:0]  cmdAddrBytes,
  input  logic [DUMMY_CNT_W-1:0] cmdDummyBytes,
  input  logic [DCNT_W-1:0]      cmdDataBytes,
  input  logic                   cmdRead,
  input  logic [DIV_W-1:0]       divFlash,
  input  logic [DIV_W-1:0]       divEeprom,
  output logic                   cmdEnable,
  output logic                   wrTimerActive,
  output logic                   errSticky,
  output logic [DATA_W-1:0]      dataOut,
  output logic                   sclk,
  output logic [1:0]             csN,
  output logic                   mosi,
  input  logic                   miso
);

  ctrlStrobeT stb;

  spiHostCtrl #(
    .DIV_W(DIV_W), .DATA_BYTES(DATA_BYTES), .ADDR_CNT_W(ADDR_CNT_W),
    .DUMMY_CNT_W(DUMMY_CNT_W), .DCNT_W(DCNT_W), .WR_TIMER_CYCLES(WR_TIMER_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdDevSel(cmdDevSel),
    .cmdAddrBytes(cmdAddrBytes), .cmdDummyBytes(cmdDummyBytes),
    .cmdDataBytes(cmdDataBytes), .cmdRead(cmdRead),
    .divFlash(divFlash), .divEeprom(divEeprom), .stb(stb),
    .cmdEnable(cmdEnable), .sclk(sclk), .csN(csN),
    .wrTimerActive(wrTimerActive), .errSticky(errSticky)
  );

  spiHostDatapath #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(cmdEnable),
    .addrWr(addrWr), .addrIn(addrIn), .dataWr(dataWr), .dataIn(dataIn),
    .cmdOpcode(cmdOpcode), .miso(miso), .mosi(mosi), .dataOut(dataOut)
  );

endmodule

// File: rtl/spiHostEngineChecker.sv
module spiHostEngineChecker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWr,
  input logic       cmdEnable,
  input logic [1:0] csN,
  input logic       sclk,
  input logic       wrTimerActive,
  input logic       errSticky
);

  AST_ENABLE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdEnable) |-> $past(cmdWr)); // R1

  AST_CS_ONLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (csN != 2'b11) |-> cmdEnable); // R1

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R5

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN == 2'b11) |-> !sclk); // R7

  AST_TIMER_STARTS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrTimerActive) |-> $fell(cmdEnable)); // R8

  AST_ERR_STAYS_SET: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R9

endmodule

bind spiHostEngine spiHostEngineChecker u_checker (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdEnable(cmdEnable), .csN(csN),
  .sclk(sclk), .wrTimerActive(wrTimerActive), .errSticky(errSticky)
);

// File: tb/spiHostEngine_bench.sv
`timescale 1ns/1ps
module spiHostEngine_bench;

  localparam int TMR = 20;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         addrWr = 0, dataWr = 0, cmdWr = 0;
  logic [23:0]  addrIn = '0;
  logic [127:0] dataIn = '0;
  logic [7:0]   cmdOpcode = '0;
  logic         cmdDevSel = 0, cmdRead = 0;
  logic [1:0]   cmdAddrBytes = '0, cmdDummyBytes = '0;
  logic [4:0]   cmdDataBytes = '0;
  logic [6:0]   divFlash = 7'd1, divEeprom = 7'd4;
  logic         cmdEnable, wrTimerActive, errSticky, sclk, mosi, miso;
  logic [127:0] dataOut;
  logic [1:0]   csN;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spiHostEngine #(.WR_TIMER_CYCLES(TMR)) u_spiHostEngine (
    .clk(clk), .rstN(rstN), .addrWr(addrWr), .addrIn(addrIn), .dataWr(dataWr),
    .dataIn(dataIn), .cmdWr(cmdWr), .cmdOpcode(cmdOpcode), .cmdDevSel(cmdDevSel),
    .cmdAddrBytes(cmdAddrBytes), .cmdDummyBytes(cmdDummyBytes),
    .cmdDataBytes(cmdDataBytes), .cmdRead(cmdRead), .divFlash(divFlash),
    .divEeprom(divEeprom), .cmdEnable(cmdEnable), .wrTimerActive(wrTimerActive),
    .errSticky(errSticky), .dataOut(dataOut), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // ---------------- device model ----------------
  logic       csIdle;
  int         slvBits = 0;
  int         lastBits = 0;
  logic [1:0] lastCs = 2'b11;
  logic [7:0] frameBytes [32];

  function automatic logic [7:0] slaveByte(input int k);
    return 8'((k * 29 + 165) & 255);
  endfunction

  function automatic logic [7:0] patByte(input int k, input int i);
    return 8'((i * 17 + k * 3 + 1) & 255);
  endfunction

  assign csIdle = &csN;
  assign miso   = slaveByte(slvBits / 8)[7 - (slvBits % 8)];

  always @(posedge sclk or posedge csIdle) begin
    if (csIdle) begin
      lastBits = slvBits;
      slvBits  = 0;
    end else begin
      frameBytes[(slvBits / 8) % 32][7 - (slvBits % 8)] = mosi;
      lastCs  = csN;
      slvBits = slvBits + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadRegs(input logic [23:0] a, input int k);
    @(negedge clk);
    addrIn = a; addrWr = 1;
    for (int i = 0; i < 16; i++) dataIn[8*i +: 8] = patByte(k, i);
    dataWr = 1;
    @(negedge clk);
    addrWr = 0; dataWr = 0;
  endtask

  task automatic issue(input logic [7:0] op, input logic dev, input int a,
                       input int d, input int n, input logic rd);
    @(negedge clk);
    cmdOpcode = op; cmdDevSel = dev; cmdAddrBytes = 2'(a);
    cmdDummyBytes = 2'(d); cmdDataBytes = 5'(n); cmdRead = rd; cmdWr = 1;
    @(negedge clk);
    cmdWr = 0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (cmdEnable && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) check(0, "R1 transaction never completed", 1, 0);
  endtask

  function automatic logic [7:0] expByte(input int j, input logic [7:0] op,
      input int a, input int d, input logic rd, input logic [23:0] ad, input int k);
    if (j == 0) return op;
    if (j <= a) return ad[8*(a-j) +: 8];
    if (j <= a + d) return 8'h00;
    if (rd) return 8'h00;
    return patByte(k, j - 1 - a - d);
  endfunction

  task automatic checkFrame(input string tag, input logic [7:0] op, input int a,
      input int d, input int n, input logic rd, input logic [23:0] ad, input int k);
    int bad = -1;
    check(lastBits == 8 * (1 + a + d + n), {tag, " R3 frame length"},
          128'(lastBits), 128'(8 * (1 + a + d + n)));
    for (int j = 0; j < 1 + a + d + n; j++)
      if (bad < 0 && frameBytes[j] !== expByte(j, op, a, d, rd, ad, k)) bad = j;
    if (bad < 0) check(1, {tag, " R2 frame bytes"}, 0, 0);
    else check(0, {tag, " R2 frame bytes"}, 128'(frameBytes[bad]),
               128'(expByte(bad, op, a, d, rd, ad, k)));
  endtask

  task automatic measure(input logic dev, input int hp);
    int lead = 0, per = 0, gap = 0;
    issue(8'h9F, dev, 0, 0, 0, 1'b1);
    while (!sclk) begin @(negedge clk); lead++; end
    check(lead == hp, "R7 chip select lead", 128'(lead), 128'(hp));
    do begin @(negedge clk); per++; end while (sclk);
    do begin @(negedge clk); per++; end while (!sclk);
    check(per == 2 * hp, "R6 sclk period", 128'(per), 128'(2 * hp));
    while (csN != 2'b11) @(negedge clk);
    while (cmdEnable && gap < 1000) begin gap++; @(negedge clk); end
    check(gap == 2 * hp, "R7 deselect gap", 128'(gap), 128'(2 * hp));
  endtask

  // {opcode, dev, addrBytes, dummyBytes, dataBytes, read, pad}
  localparam logic [23:0] VEC [6] = '{
    {8'h03, 1'b0, 2'd3, 2'd0, 5'd4,  1'b1, 5'd0},
    {8'h02, 1'b1, 2'd2, 2'd0, 5'd5,  1'b0, 5'd0},
    {8'h0B, 1'b0, 2'd3, 2'd1, 5'd8,  1'b1, 5'd0},
    {8'h05, 1'b1, 2'd0, 2'd0, 5'd1,  1'b1, 5'd0},
    {8'h06, 1'b1, 2'd0, 2'd0, 5'd0,  1'b0, 5'd0},
    {8'h02, 1'b0, 2'd1, 2'd2, 5'd16, 1'b0, 5'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cmdEnable == 0 && wrTimerActive == 0 && errSticky == 0 && sclk == 0,
          "R10 flags after reset", {cmdEnable, wrTimerActive, errSticky, sclk}, 0);
    check(csN == 2'b11, "R10 selects after reset", 128'(csN), 128'(2'b11));
    check(dataOut == '0, "R10 data after reset", dataOut, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      logic [7:0] op; logic dev, rd; int a, d, n;
      logic [23:0] ad; logic [127:0] expData;
      op = VEC[k][23:16]; dev = VEC[k][15]; a = int'(VEC[k][14:13]);
      d = int'(VEC[k][12:11]); n = int'(VEC[k][10:6]); rd = VEC[k][5];
      ad = 24'hC0FFEE ^ 24'(k * 24'h111111);
      loadRegs(ad, k);
      issue(op, dev, a, d, n, rd);
      check(cmdEnable == 1, "R1 enable set after launch", 128'(cmdEnable), 1);
      waitIdle();
      checkFrame($sformatf("vec%0d", k), op, a, d, n, rd, ad, k);
      check(lastCs == (dev ? 2'b01 : 2'b10), "R5 select line",
            128'(lastCs), 128'(dev ? 2'b01 : 2'b10));
      for (int i = 0; i < 16; i++)
        expData[8*i +: 8] = (rd && i < n) ? slaveByte(1 + a + d + i) : patByte(k, i);
      check(dataOut == expData, "R4 data register after transfer", dataOut, expData);
      check(wrTimerActive == (!rd && n > 0), "R8 write timer start",
            128'(wrTimerActive), 128'(!rd && n > 0));
      repeat (TMR + 2) @(negedge clk);
    end
    check(errSticky == 0, "R9 no error without clamp", 128'(errSticky), 0);

    // R1 / R11: command, address and data writes while busy are ignored
    loadRegs(24'hABCDEF, 9);
    issue(8'h02, 1'b1, 2, 0, 4, 1'b0);
    repeat (10) @(negedge clk);
    cmdOpcode = 8'hAA; cmdRead = 1; cmdWr = 1; addrIn = 24'h111111; addrWr = 1;
    for (int i = 0; i < 16; i++) dataIn[8*i +: 8] = patByte(10, i);
    dataWr = 1;
    @(negedge clk);
    cmdWr = 0; addrWr = 0; dataWr = 0;
    waitIdle();
    checkFrame("busy R11", 8'h02, 2, 0, 4, 1'b0, 24'hABCDEF, 9);
    begin
      logic [127:0] expData;
      for (int i = 0; i < 16; i++) expData[8*i +: 8] = patByte(9, i);
      check(dataOut == expData, "R11 data write while busy ignored", dataOut, expData);
    end
    // R8 window length
    begin
      int t = 0;
      while (wrTimerActive && t < 1000) begin t++; @(negedge clk); end
      check(t == TMR, "R8 write timer length", 128'(t), 128'(TMR));
    end
    check(cmdEnable == 0 && csN == 2'b11, "R1 busy command not queued",
          {cmdEnable, csN}, 128'(3));

    // R6 / R7 timing
    divEeprom = 7'd7;
    measure(1'b1, 4);
    divFlash = 7'd0;
    measure(1'b0, 1);
    divFlash = 7'd1; divEeprom = 7'd4;

    // R9 clamp
    loadRegs(24'h000100, 5);
    issue(8'h02, 1'b0, 0, 0, 20, 1'b0);
    waitIdle();
    check(lastBits == 8 * 17, "R9 clamped length", 128'(lastBits), 128'(8 * 17));
    check(errSticky == 1, "R9 error set", 128'(errSticky), 1);
    repeat (TMR + 2) @(negedge clk);
    issue(8'h03, 1'b1, 1, 0, 2, 1'b1);
    waitIdle();
    check(errSticky == 1, "R9 error sticky", 128'(errSticky), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule